// File: doc/BRIEF.md
# Bit-Serial Odd Parity Register Pair

This block keeps two 8-bit words, called R and S, and fills in bit 0 of either one with an odd parity bit. A load strobe writes seven data bits into the upper part of the chosen word. A check strobe starts a small controller. The controller visits bits 7 down to 1 of the chosen word, one bit per clock, and toggles a parity accumulator for every 1 it finds. It then writes the result into bit 0 and copies the finished word onto an 8-bit display bus. The display keeps that value until the next check finishes.

The controller has three states, which are the `ctrl_state_t` values listed here:
- ST_IDLE waits for strobes. When a check strobe arrives with no load strobe, the controller latches the select input and moves to ST_SCAN.
- ST_SCAN folds one register bit into the accumulator per clock, starting at bit 7. After it handles bit 1, it moves to ST_WRITE.
- ST_WRITE stores the parity bit, updates the display and returns to ST_IDLE.

Reset returns the controller to ST_IDLE from any state.

Top module: `oddpar_regpair`

## Requirements
- R1: While reset is high, and after it is released, both words hold all zeros, the display bus reads 0 and busy is low. A reset during a check abandons that check.
- R2: When idle, a load strobe writes `data_i[k]` into bit k+1 of the selected word, for k = 0 to 6. A load alone does not change the display bus.
- R3: For both load and check, a select value of 0 chooses word R and a value of 1 chooses word S.
- R4: A check strobe taken while idle raises busy from the next cycle. Busy stays high for exactly 8 cycles: seven scan cycles and one write cycle.
- R5: The check stores in bit 0 of the selected word a value that makes the number of ones in bits 7 to 0 odd.
- R6: In the cycle after busy falls, the display bus equals bits 7 to 0 of the checked word. It holds that value until the next check completes or a reset occurs.
- R7: The select value is captured with the check strobe. Changing `sel_i` while busy has no effect on which word is checked or written.
- R8: Load and check strobes that arrive while busy is high are ignored.
- R9: If a load strobe and a check strobe are both high in the same idle cycle, the load is performed and the check is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| load_i | input | 1 | One-cycle load strobe |
| check_i | input | 1 | One-cycle check strobe |
| sel_i | input | 1 | Word select: 0 chooses R, 1 chooses S |
| data_i | input | DATA_W (7) | Data written into bits 7 to 1 of the selected word |
| disp_o | output | DATA_W+1 (8) | Contents of the most recently checked word |
| busy_o | output | 1 | High while a check is in progress |

## Verification
The assertions assume that the strobes are synchronous to `clk` and are never X after reset. They also assume that reset is the only event that interrupts a check. The bench drives every input at the falling edge, so each strobe is sampled by exactly one rising edge. Strobes are deliberately sent while busy is high, toggled against the select input, and raised together with another strobe. A reset is also applied partway through a check. All of these stimuli stay within the synchronous, single-edge assumption the properties rely on.

// File: rtl/oddpar_pkg.sv
package oddpar_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SCAN  = 2'd1,
        ST_WRITE = 2'd2
    } ctrl_state_t;

    localparam int NUM_WORDS = 2;
endpackage

// File: rtl/oddpar_regbank.sv
module oddpar_regbank #(
    parameter int DATA_W = 7,
    localparam int REG_W = DATA_W + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ld_en,
    input  logic              ld_sel,
    input  logic [DATA_W-1:0] ld_data,
    input  logic              pw_en,
    input  logic              rd_sel,
    input  logic              pw_bit,
    output logic [REG_W-1:0]  rd_word
);
    import oddpar_pkg::*;

    logic [REG_W-1:0] word_q [NUM_WORDS];

    // One copy of the word register per selectable word.
    for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
        always_ff @(posedge clk) begin
            if (rst) begin
                word_q[w] <= '0;
            end else begin
                if (ld_en && (ld_sel == w[0])) begin
                    word_q[w][REG_W-1:1] <= ld_data;
                end
                if (pw_en && (rd_sel == w[0])) begin
                    word_q[w][0] <= pw_bit;
                end
            end
        end
    end

    assign rd_word = word_q[rd_sel];

    AST_LOAD_UPPER: assert property (@(posedge clk) disable iff (rst)
        (ld_en && !ld_sel) |=> (word_q[0][REG_W-1:1] == $past(ld_data)))
        else $error("load did not land in upper bits"); // R2
endmodule

// File: rtl/oddpar_ctrl.sv
module oddpar_ctrl #(
    parameter int REG_W = 8,
    localparam int IDX_W = $clog2(REG_W)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load_i,
    input  logic             check_i,
    input  logic             sel_i,
    input  logic [REG_W-1:0] rd_word,
    output logic             ld_en,
    output logic             pw_en,
    output logic             pw_bit,
    output logic             sel_q,
    output logic             busy
);
    import oddpar_pkg::*;

    ctrl_state_t state_q, state_d;
    logic [IDX_W-1:0] idx_q;
    logic             acc_q;
    logic             start;

    assign start = (state_q == ST_IDLE) && check_i && !load_i;

    // State register
    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (start) state_d = ST_SCAN;
            ST_SCAN:  if (idx_q == IDX_W'(1)) state_d = ST_WRITE;
            ST_WRITE: state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // Scan datapath: bit index, parity accumulator, captured select
    always_ff @(posedge clk) begin
        if (rst) begin
            idx_q <= '0;
            acc_q <= 1'b1;
            sel_q <= 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE: if (start) begin
                    idx_q <= IDX_W'(REG_W - 1);
                    acc_q <= 1'b1;
                    sel_q <= sel_i;
                end
                ST_SCAN: begin
                    acc_q <= acc_q ^ rd_word[idx_q];
                    idx_q <= idx_q - IDX_W'(1);
                end
                default: ;
            endcase
        end
    end

    // Outputs
    always_comb begin
        busy   = (state_q != ST_IDLE);
        ld_en  = (state_q == ST_IDLE) && load_i;
        pw_en  = (state_q == ST_WRITE);
        pw_bit = acc_q;
    end

    AST_SEL_HELD: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_SCAN) |=> $stable(sel_q))
        else $error("select changed mid-check"); // R7

    AST_WRITE_ENDS_BUSY: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_WRITE) |=> !busy)
        else $error("busy outlived the write"); // R4

    AST_START_RAISES_BUSY: assert property (@(posedge clk) disable iff (rst)
        start |=> busy)
        else $error("check did not raise busy"); // R4
endmodule

// File: rtl/oddpar_regpair.sv
module oddpar_regpair #(
    parameter int DATA_W = 7,
    localparam int REG_W = DATA_W + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load_i,
    input  logic              check_i,
    input  logic              sel_i,
    input  logic [DATA_W-1:0] data_i,
    output logic [REG_W-1:0]  disp_o,
    output logic              busy_o
);
    logic             ld_en;
    logic             pw_en;
    logic             pw_bit;
    logic             sel_q;
    logic             rd_sel;
    logic [REG_W-1:0] rd_word;

    assign rd_sel = busy_o ? sel_q : sel_i;

    oddpar_ctrl #(.REG_W(REG_W)) u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .load_i  (load_i),
        .check_i (check_i),
        .sel_i   (sel_i),
        .rd_word (rd_word),
        .ld_en   (ld_en),
        .pw_en   (pw_en),
        .pw_bit  (pw_bit),
        .sel_q   (sel_q),
        .busy    (busy_o)
    );

    oddpar_regbank #(.DATA_W(DATA_W)) u_bank (
        .clk     (clk),
        .rst     (rst),
        .ld_en   (ld_en),
        .ld_sel  (sel_i),
        .ld_data (data_i),
        .pw_en   (pw_en),
        .rd_sel  (rd_sel),
        .pw_bit  (pw_bit),
        .rd_word (rd_word)
    );

    // Display register: updated only when the parity bit is written
    always_ff @(posedge clk) begin
        if (rst)        disp_o <= '0;
        else if (pw_en) disp_o <= {rd_word[REG_W-1:1], pw_bit};
    end

    AST_ODD_RESULT: assert property (@(posedge clk) disable iff (rst)
        pw_en |=> (^disp_o))
        else $error("display parity is even"); // R5

    AST_DISP_HOLD: assert property (@(posedge clk) disable iff (rst)
        !pw_en |=> $stable(disp_o))
        else $error("display moved without a write"); // R6

    AST_WORD_FROZEN: assert property (@(posedge clk) disable iff (rst)
        (busy_o && !pw_en) |=> $stable(rd_word))
        else $error("word changed during scan"); // R8
endmodule

// File: tb/oddpar_regpair_tb.sv
module oddpar_regpair_tb;
    localparam int DW = 7;
    localparam int RW = DW + 1;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          load_i = 1'b0;
    logic          check_i = 1'b0;
    logic          sel_i = 1'b0;
    logic [DW-1:0] data_i = '0;
    logic [RW-1:0] disp_o;
    logic          busy_o;

    int errors = 0;
    int checks = 0;
    int cycles = 0;

    // Reference model state
    logic [RW-1:0] m_word [2];
    logic [RW-1:0] m_disp;
    int            m_cnt;
    logic          m_sel;

    always #2.5 clk = ~clk;

    oddpar_regpair #(.DATA_W(DW)) u_dut (
        .clk(clk), .rst(rst), .load_i(load_i), .check_i(check_i),
        .sel_i(sel_i), .data_i(data_i), .disp_o(disp_o), .busy_o(busy_o)
    );

    function automatic logic odd_bit(input logic [DW-1:0] d);
        return ~(^d);
    endfunction

    // Behavioural model, advanced on every rising edge
    always @(posedge clk) begin
        if (rst) begin
            m_word[0] = '0;
            m_word[1] = '0;
            m_disp = '0;
            m_cnt = 0;
            m_sel = 1'b0;
        end else if (m_cnt > 0) begin
            m_cnt = m_cnt - 1;
            if (m_cnt == 0) begin
                m_word[m_sel][0] = odd_bit(m_word[m_sel][RW-1:1]);
                m_disp = m_word[m_sel];
            end
        end else if (load_i) begin
            m_word[sel_i][RW-1:1] = data_i;
        end else if (check_i) begin
            m_sel = sel_i;
            m_cnt = 8;
        end
    end

    // Per-cycle comparison at the falling edge
    always @(negedge clk) begin
        cycles++;
        if (!rst) begin
            checks++;
            if (disp_o !== m_disp) begin
                errors++;
                $display("FAIL R6 cycle %0d: disp=%h expected %h", cycles, disp_o, m_disp);
            end
            checks++;
            if (busy_o !== (m_cnt > 0)) begin
                errors++;
                $display("FAIL R4 cycle %0d: busy=%b expected %b", cycles, busy_o, (m_cnt > 0));
            end
        end
        if (cycles > 100000) begin
            errors++;
            $display("FAIL watchdog: cycles=%0d expected below 100000", cycles);
            $display("Result: errors=%0d of %0d checks", errors, checks + 1);
            $finish;
        end
    end

    task automatic check_eq(input string tag, input logic [RW-1:0] got, input logic [RW-1:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic do_load(input logic s, input logic [DW-1:0] d);
        @(negedge clk); load_i = 1'b1; sel_i = s; data_i = d;
        @(negedge clk); load_i = 1'b0;
    endtask

    task automatic do_check(input logic s);
        @(negedge clk); check_i = 1'b1; sel_i = s;
        @(negedge clk); check_i = 1'b0;
        repeat (8) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check_eq("R1 reset disp", disp_o, '0);
        check_eq("R1 reset busy", {7'd0, busy_o}, '0);
        rst = 1'b0;
        @(negedge clk);

        // R1: zero words check to all-zero data with parity 1
        do_check(1'b0);
        check_eq("R1 word R zero after reset", disp_o, 8'h01);

        // R2 R3 R5: load R, check it
        do_load(1'b0, 7'h55);
        check_eq("R2 load leaves display", disp_o, 8'h01);
        do_check(1'b0);
        check_eq("R5 word R 0x55", disp_o, {7'h55, odd_bit(7'h55)});

        // R3: load S, check it; R must stay intact
        do_load(1'b1, 7'h7F);
        do_check(1'b1);
        check_eq("R3 word S 0x7F", disp_o, {7'h7F, 1'b0});
        do_check(1'b0);
        check_eq("R3 word R untouched", disp_o, {7'h55, 1'b1});

        // R7: toggle select during check
        do_load(1'b1, 7'h03);
        @(negedge clk); check_i = 1'b1; sel_i = 1'b1;
        @(negedge clk); check_i = 1'b0; sel_i = 1'b0;
        repeat (3) @(negedge clk); sel_i = 1'b1;
        repeat (5) @(negedge clk);
        check_eq("R7 latched select", disp_o, {7'h03, 1'b1});

        // R8: strobes while busy
        @(negedge clk); check_i = 1'b1; sel_i = 1'b0;
        @(negedge clk); check_i = 1'b0;
        @(negedge clk); load_i = 1'b1; data_i = 7'h00;
        @(negedge clk); load_i = 1'b0; check_i = 1'b1; sel_i = 1'b1;
        @(negedge clk); check_i = 1'b0;
        repeat (5) @(negedge clk);
        check_eq("R8 busy strobes ignored", disp_o, {7'h55, 1'b1});
        check_eq("R8 idle after", {7'd0, busy_o}, '0);

        // R9: simultaneous load and check
        @(negedge clk); load_i = 1'b1; check_i = 1'b1; sel_i = 1'b0; data_i = 7'h01;
        @(negedge clk); load_i = 1'b0; check_i = 1'b0;
        check_eq("R9 no check started", {7'd0, busy_o}, '0);
        do_check(1'b0);
        check_eq("R9 load applied", disp_o, {7'h01, 1'b0});

        // R1: reset mid-check
        @(negedge clk); check_i = 1'b1; sel_i = 1'b1;
        @(negedge clk); check_i = 1'b0;
        repeat (3) @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        check_eq("R1 reset mid-check disp", disp_o, '0);
        check_eq("R1 reset mid-check busy", {7'd0, busy_o}, '0);
        do_check(1'b1);
        check_eq("R1 word S cleared", disp_o, 8'h01);

        repeat (2) @(negedge clk);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule